// File: doc/BRIEF.md
# Multichannel Conversion Sequencer with Averaging

This block shares one sample converter among several input channels. Channels take turns in a fixed order. Each turn, called a slot, holds the converter for N back-to-back conversions of one channel. At the end of the slot the N samples are averaged into that channel's result register, and a one-cycle valid pulse for that channel is raised. Channels that are masked off are skipped and take no slots. With M channels enabled, each result therefore refreshes about once every N·M conversion times.

A start pulse begins a pass over the enabled channels. In single-shot operation the block completes one pass, raises a completion flag and drops back into a low-power idle state. In continuous operation it keeps rotating until single-shot is selected again or power-down is requested. A power-down request stops all new conversions and keeps every result readable. The averaging depth and the operating mode are taken only when a slot begins, so an average never mixes two depths.

The converter is reached through two valid/ready streams:

- **Request stream.** Once the request valid is raised, valid and the channel number are held unchanged until ready is seen high at a clock edge. The converter may stall the request stream for any number of cycles.
- **Response stream.** A sample is taken at the edge where response valid and response ready are both high. Response ready is raised only while a requested sample is outstanding. The converter must keep response valid and the sample stable until that edge.

The result outputs are plain registers with a notification pulse. They have no back-pressure.

Top module: `conv_seq_avg`

## Requirements
- R1: Enabled channels are served in ascending index order, wrapping from the highest enabled index back to the lowest. Each slot issues N consecutive requests for the same channel.
- R2: A channel whose enable bit is 0 when a slot is chosen receives no request. M enabled channels give exactly M slots per pass.
- R3: A start pulse clears `data_rdy` and begins a pass. `data_rdy` rises in the same cycle as the result of the last enabled channel of a pass. In single-shot operation (`mode_cont`=0) the block then returns to idle. In continuous operation (`mode_cont`=1) the next pass follows without a new start. Mode is read only when a pass wraps, so a pass in progress always completes.
- R4: Averaging-depth code k (0..7) gives N = 2^k. Samples are signed two's complement, SW bits wide. The result is floor((sum + 2^(k-1)) / 2^k), or the plain sum when k = 0. The accumulator carries 7 guard bits, so 128 full-scale samples neither overflow nor wrap.
- R5: Channel i's result occupies `res_flat[i*SW +: SW]`. It changes only in the cycle where `res_vld[i]` is high. `res_vld` is a one-cycle pulse with at most one bit set.
- R6: While `pd_req` is high, no new request is issued and start is ignored. A sample already requested is accepted and discarded, the partial average is dropped, and all results keep their values.
- R7: With an all-zero enable mask, start is ignored: the block stays idle and `data_rdy` never rises.
- R8: The depth code and mode are sampled when a slot begins. A depth change in the middle of a slot leaves that slot's N unchanged and applies to the next slot.
- R9: The request and response streams obey the valid/ready rules stated above. The response stream is only ready while no request is pending.
- R10: `busy` is high from the cycle after an accepted start until the block returns to idle. `pwr_dn` is its complement, and no request is raised while `pwr_dn` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | NCH | Per-channel enable mask |
| mode_cont | input | 1 | 1 = continuous, 0 = single-shot |
| start | input | 1 | One-cycle pulse that begins a pass from idle |
| avg_code | input | 3 | Averaging depth code, N = 2^code |
| pd_req | input | 1 | Power-down request |
| cnv_req_valid | output | 1 | Conversion request valid |
| cnv_req_ready | input | 1 | Converter accepts request |
| cnv_req_chan | output | CW | Channel to convert |
| cnv_rsp_valid | input | 1 | Sample valid from converter |
| cnv_rsp_ready | output | 1 | Sequencer accepts sample |
| cnv_rsp_data | input | SW | Signed sample |
| res_flat | output | NCH*SW | Packed per-channel averaged results |
| res_vld | output | NCH | Per-channel result-updated pulse |
| data_rdy | output | 1 | Pass-complete flag |
| busy | output | 1 | Sequencer active |
| pwr_dn | output | 1 | Low-power idle indication |

## Verification
The checker watches several properties on every cycle:

- request stability under stall and the exclusive readiness of the response stream;
- the one-hot result pulse and the freezing of each result between its pulses;
- the coincidence of a rising `data_rdy` with a result write;
- the absence of requests while idle, powered down or without enabled channels.

Other behaviours need the bench's scenarios, because they depend on sample values and on whole passes. These are the rotation order and the skipping of disabled channels, the rounded averages at every depth including full-scale extremes, the single-shot pass length, and continuous passes completing after a mode switch. So are the deferred depth change and the discarding of a partial average on power-down.

// File: rtl/cs_pkg.sv
package cs_pkg;
  // Width of the averaging depth code; depths are 1 .. 2**(2**DEPTH_W-1)
  localparam int DEPTH_W = 3;
  // Guard bits so the largest sum of full-scale samples fits
  localparam int GUARD = (1 << DEPTH_W) - 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEL  = 2'd1,
    ST_REQ  = 2'd2,
    ST_WAIT = 2'd3
  } seq_state_t;

  function automatic int chan_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cs_chan_pick.sv
module cs_chan_pick import cs_pkg::*; #(
  parameter int NCH = 4,
  localparam int CW = chan_w(NCH)
) (
  input  logic [NCH-1:0] mask,
  input  logic [CW-1:0]  cur,
  input  logic           from_start,
  output logic           found,
  output logic [CW-1:0]  nxt,
  output logic           wrap
);
  logic [CW-1:0] lowest;
  logic [CW-1:0] above;
  logic          above_ok;

  // Lowest enabled index overall, and lowest enabled index above cur
  always_comb begin
    lowest   = '0;
    above    = '0;
    above_ok = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i]) begin
        lowest = CW'(i);
        if (CW'(i) > cur) begin
          above    = CW'(i);
          above_ok = 1'b1;
        end
      end
    end
  end

  assign found = |mask;
  assign wrap  = !from_start && !above_ok;
  assign nxt   = (from_start || !above_ok) ? lowest : above;
endmodule

// File: rtl/cs_avg_accum.sv
module cs_avg_accum import cs_pkg::*; #(
  parameter int SW = 16,
  localparam int AW = SW + GUARD
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                add,
  input  logic signed [SW-1:0] sample,
  input  logic [DEPTH_W-1:0]  shift,
  output logic                last,
  output logic signed [SW-1:0] avg
);
  logic signed [AW-1:0] acc_q;
  logic [GUARD-1:0]     cnt_q;
  logic signed [AW-1:0] smp_ext;
  logic signed [AW-1:0] sum_nx;
  logic signed [AW-1:0] half;
  logic signed [AW-1:0] rnd;
  logic [GUARD:0]       lim;

  assign smp_ext = sample;
  assign sum_nx  = acc_q + smp_ext;
  assign half    = (shift == '0) ? '0 : (AW'(1) << (shift - DEPTH_W'(1)));
  assign rnd     = (sum_nx + half) >>> shift;
  assign avg     = SW'(rnd);
  assign lim     = ((GUARD+1)'(1) << shift) - (GUARD+1)'(1);
  assign last    = ({1'b0, cnt_q} == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (add) begin
      acc_q <= sum_nx;
      cnt_q <= cnt_q + GUARD'(1);
    end
  end
endmodule

// File: rtl/cs_result_bank.sv
module cs_result_bank import cs_pkg::*; #(
  parameter int NCH = 4,
  parameter int SW  = 16,
  localparam int CW = chan_w(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [CW-1:0]     wch,
  input  logic [SW-1:0]     wdata,
  output logic [NCH*SW-1:0] res_flat,
  output logic [NCH-1:0]    res_vld
);
  for (genvar g = 0; g < NCH; g++) begin : g_slot
    logic [SW-1:0] val_q;
    logic          hit;
    assign hit = wen && (wch == CW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val_q      <= '0;
        res_vld[g] <= 1'b0;
      end else begin
        res_vld[g] <= hit;
        if (hit) val_q <= wdata;
      end
    end
    assign res_flat[g*SW +: SW] = val_q;
  end
endmodule

// File: rtl/conv_seq_avg.sv
module conv_seq_avg import cs_pkg::*; #(
  parameter int NCH = 4,
  parameter int SW  = 16,
  localparam int CW = chan_w(NCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       chan_en,
  input  logic                 mode_cont,
  input  logic                 start,
  input  logic [DEPTH_W-1:0]   avg_code,
  input  logic                 pd_req,
  output logic                 cnv_req_valid,
  input  logic                 cnv_req_ready,
  output logic [CW-1:0]        cnv_req_chan,
  input  logic                 cnv_rsp_valid,
  output logic                 cnv_rsp_ready,
  input  logic signed [SW-1:0] cnv_rsp_data,
  output logic [NCH*SW-1:0]    res_flat,
  output logic [NCH-1:0]       res_vld,
  output logic                 data_rdy,
  output logic                 busy,
  output logic                 pwr_dn
);
  seq_state_t         state_q;
  logic [CW-1:0]      cur_q;
  logic [DEPTH_W-1:0] shift_q;
  logic               first_q;
  logic               rdy_q;

  logic               pk_found;
  logic [CW-1:0]      pk_nxt;
  logic               pk_wrap;
  logic               rsp_fire;
  logic               acc_add;
  logic               acc_last;
  logic signed [SW-1:0] acc_avg;
  logic               wr_en;
  logic               sel_go;

  cs_chan_pick #(.NCH(NCH)) pick_i (
    .mask       (chan_en),
    .cur        (cur_q),
    .from_start (first_q),
    .found      (pk_found),
    .nxt        (pk_nxt),
    .wrap       (pk_wrap)
  );

  assign rsp_fire = (state_q == ST_WAIT) && cnv_rsp_valid;
  assign acc_add  = rsp_fire && !pd_req;
  assign wr_en    = acc_add && acc_last;
  // A slot begins only with an enabled channel, no power-down, and either
  // more channels left in this pass or continuous mode at the wrap
  assign sel_go   = pk_found && !pd_req && (!pk_wrap || mode_cont);

  cs_avg_accum #(.SW(SW)) acc_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (state_q == ST_SEL),
    .add    (acc_add),
    .sample (cnv_rsp_data),
    .shift  (shift_q),
    .last   (acc_last),
    .avg    (acc_avg)
  );

  cs_result_bank #(.NCH(NCH), .SW(SW)) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wen      (wr_en),
    .wch      (cur_q),
    .wdata    (acc_avg),
    .res_flat (res_flat),
    .res_vld  (res_vld)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      shift_q <= '0;
      first_q <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start && (|chan_en) && !pd_req) begin
            rdy_q   <= 1'b0;
            first_q <= 1'b1;
            state_q <= ST_SEL;
          end
        end
        ST_SEL: begin
          if (sel_go) begin
            cur_q   <= pk_nxt;
            shift_q <= avg_code;
            first_q <= 1'b0;
            state_q <= ST_REQ;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_REQ: begin
          if (cnv_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_fire) begin
            if (pd_req) begin
              state_q <= ST_IDLE;
            end else if (acc_last) begin
              if (pk_wrap) rdy_q <= 1'b1;
              state_q <= ST_SEL;
            end else begin
              state_q <= ST_REQ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv_req_valid = (state_q == ST_REQ);
  assign cnv_req_chan  = cur_q;
  assign cnv_rsp_ready = (state_q == ST_WAIT);
  assign data_rdy      = rdy_q;
  assign busy          = (state_q != ST_IDLE);
  assign pwr_dn        = (state_q == ST_IDLE);
endmodule

// File: rtl/conv_seq_avg_chk.sv
module conv_seq_avg_chk import cs_pkg::*; #(
  parameter int NCH = 4,
  parameter int SW  = 16,
  localparam int CW = chan_w(NCH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    chan_en,
  input logic              pd_req,
  input logic              cnv_req_valid,
  input logic              cnv_req_ready,
  input logic [CW-1:0]     cnv_req_chan,
  input logic              cnv_rsp_ready,
  input logic [NCH*SW-1:0] res_flat,
  input logic [NCH-1:0]    res_vld,
  input logic              data_rdy,
  input logic              busy,
  input logic              pwr_dn
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_req_valid && !cnv_req_ready) |=> (cnv_req_valid && $stable(cnv_req_chan)));

  assert_rsp_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_rsp_ready |-> !cnv_req_valid);

  assert_vld_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_vld));

  for (genvar g = 0; g < NCH; g++) begin : g_hold
    assert_res_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !res_vld[g] |-> $stable(res_flat[g*SW +: SW]));
  end

  assert_rdy_with_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_rdy) |-> (|res_vld));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> (!cnv_req_valid && !busy));

  assert_pd_stays_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_req && !busy) |=> !busy);

  assert_zero_mask_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_en == '0) && !busy) |=> !busy);
endmodule

bind conv_seq_avg conv_seq_avg_chk #(.NCH(NCH), .SW(SW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .chan_en       (chan_en),
  .pd_req        (pd_req),
  .cnv_req_valid (cnv_req_valid),
  .cnv_req_ready (cnv_req_ready),
  .cnv_req_chan  (cnv_req_chan),
  .cnv_rsp_ready (cnv_rsp_ready),
  .res_flat      (res_flat),
  .res_vld       (res_vld),
  .data_rdy      (data_rdy),
  .busy          (busy),
  .pwr_dn        (pwr_dn)
);

// File: tb/conv_seq_avg_tb_top.sv
module conv_seq_avg_tb_top;
  localparam int NCH = 4;
  localparam int SW  = 16;
  localparam int CW  = 2;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] chan_en;
  logic mode_cont, start, pd_req;
  logic [2:0] avg_code;
  logic cnv_req_valid, cnv_req_ready;
  logic [CW-1:0] cnv_req_chan;
  logic cnv_rsp_valid, cnv_rsp_ready;
  logic signed [SW-1:0] cnv_rsp_data;
  logic [NCH*SW-1:0] res_flat;
  logic [NCH-1:0] res_vld;
  logic data_rdy, busy, pwr_dn;

  always #10 clk = ~clk;

  conv_seq_avg #(.NCH(NCH), .SW(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .mode_cont(mode_cont),
    .start(start), .avg_code(avg_code), .pd_req(pd_req),
    .cnv_req_valid(cnv_req_valid), .cnv_req_ready(cnv_req_ready),
    .cnv_req_chan(cnv_req_chan), .cnv_rsp_valid(cnv_rsp_valid),
    .cnv_rsp_ready(cnv_rsp_ready), .cnv_rsp_data(cnv_rsp_data),
    .res_flat(res_flat), .res_vld(res_vld), .data_rdy(data_rdy),
    .busy(busy), .pwr_dn(pwr_dn)
  );

  int n_chk = 0, n_fail = 0;
  int req_cnt = 0, vld_cnt = 0, rsp_cnt = 0;
  longint sum_c[NCH];
  int cnt_c[NCH];
  int k_c[NCH];
  int slot_ch = 0, slot_left = 0;
  bit pass_start = 1'b0;
  bit out_pend = 1'b0, drop_next = 1'b0;
  int lat = 0, data_mode = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int next_en(input int prev, input logic [NCH-1:0] m, input bit from_start);
    int lo = -1;
    for (int i = NCH - 1; i >= 0; i--) if (m[i]) lo = i;
    if (from_start) return lo;
    for (int i = 0; i < NCH; i++) if (m[i] && i > prev) return i;
    return lo;
  endfunction

  function automatic longint exp_avg(input longint s, input int k);
    if (k == 0) return s;
    return (s + (longint'(1) <<< (k - 1))) >>> k;
  endfunction

  function automatic longint res_of(input int c);
    logic signed [SW-1:0] r;
    r = res_flat[c*SW +: SW];
    return longint'(r);
  endfunction

  function automatic logic signed [SW-1:0] gen_sample();
    if (data_mode == 1) return 16'sh7FFF;
    if (data_mode == 2) return -16'sh8000;
    return SW'($urandom);
  endfunction

  // Converter stub and result scoreboard, all on the falling edge
  initial begin
    cnv_req_ready = 1'b0;
    cnv_rsp_valid = 1'b0;
    cnv_rsp_data  = '0;
    for (int c = 0; c < NCH; c++) begin sum_c[c] = 0; cnt_c[c] = 0; k_c[c] = 0; end
    forever begin
      @(negedge clk);
      if (rst_n) begin
        for (int c = 0; c < NCH; c++) begin
          if (res_vld[c]) begin
            vld_cnt++;
            check(cnt_c[c] == (1 << k_c[c]), "R4 samples per average", cnt_c[c], 1 << k_c[c]);
            check(res_of(c) == exp_avg(sum_c[c], k_c[c]), "R4/R5 averaged result",
                  res_of(c), exp_avg(sum_c[c], k_c[c]));
            sum_c[c] = 0;
            cnt_c[c] = 0;
          end
        end
        if (drop_next) begin
          cnv_rsp_valid = 1'b0;
          drop_next = 1'b0;
        end
        if (out_pend) begin
          if (lat > 0) lat--;
          else begin
            cnv_rsp_valid = 1'b1;
            cnv_rsp_data  = gen_sample();
            out_pend = 1'b0;
          end
        end
        if (cnv_rsp_valid && cnv_rsp_ready) begin
          sum_c[slot_ch] += longint'(cnv_rsp_data);
          cnt_c[slot_ch]++;
          rsp_cnt++;
          drop_next = 1'b1;
        end
        if (!out_pend && !cnv_rsp_valid) cnv_req_ready = (($urandom % 4) != 0);
        else cnv_req_ready = 1'b0;
        if (cnv_req_valid && cnv_req_ready) begin
          req_cnt++;
          if (slot_left == 0) begin
            check(int'(cnv_req_chan) == next_en(slot_ch, chan_en, pass_start),
                  "R1 rotation order", cnv_req_chan, next_en(slot_ch, chan_en, pass_start));
            check(chan_en[cnv_req_chan] == 1'b1, "R2 enabled channel only", chan_en[cnv_req_chan], 1);
            pass_start = 1'b0;
            slot_ch = int'(cnv_req_chan);
            k_c[slot_ch] = int'(avg_code);
            slot_left = 1 << avg_code;
          end else begin
            check(int'(cnv_req_chan) == slot_ch, "R1 same channel within slot", cnv_req_chan, slot_ch);
          end
          slot_left--;
          out_pend = 1'b1;
          lat = LAT;
        end
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    pass_start = 1'b1;
    slot_left = 0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int t = 0;
    while (busy && t < 40000) begin @(negedge clk); t++; end
    check(!busy, req, busy, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R3 actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int base_v, base_r, base_s, t;
    logic [NCH*SW-1:0] snap;
    logic [NCH-1:0] m;
    void'($urandom(32'd2024));
    rst_n = 1'b0; chan_en = '0; mode_cont = 1'b0; start = 1'b0; pd_req = 1'b0; avg_code = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    check(busy == 1'b0, "R10 reset busy", busy, 0);
    check(pwr_dn == 1'b1, "R10 reset pwr_dn", pwr_dn, 1);
    check(data_rdy == 1'b0, "R3 reset data_rdy", data_rdy, 0);
    check(res_flat == '0, "R5 reset results", res_flat, 0);

    // R7: empty mask
    base_r = req_cnt;
    pulse_start();
    repeat (40) @(negedge clk);
    check(!busy, "R7 empty mask stays idle", busy, 0);
    check(!data_rdy, "R7 empty mask no data_rdy", data_rdy, 0);
    check(req_cnt == base_r, "R7 empty mask no requests", req_cnt - base_r, 0);

    // Single-shot, mask 1011, depth 4
    chan_en = 4'b1011; avg_code = 3'd2; base_v = vld_cnt;
    pulse_start();
    check(busy && !pwr_dn, "R10 busy after start", busy, 1);
    wait_idle("R3 single-shot returns idle");
    check(vld_cnt - base_v == 3, "R3/R2 one result per enabled channel", vld_cnt - base_v, 3);
    check(data_rdy, "R3 data_rdy after pass", data_rdy, 0 + 1);
    check(pwr_dn, "R10 pwr_dn after pass", pwr_dn, 1);

    // Start clears data_rdy
    chan_en = 4'b0100; avg_code = 3'd0;
    pulse_start();
    check(!data_rdy, "R3 start clears data_rdy", data_rdy, 0);
    wait_idle("R3 second pass idle");

    // Random single-shot passes
    for (int it = 0; it < 8; it++) begin
      m = NCH'(($urandom % 15) + 1);
      chan_en = m; avg_code = 3'($urandom % 5); base_v = vld_cnt;
      pulse_start();
      wait_idle("R3 random pass idle");
      check(vld_cnt - base_v == $countones(m), "R2 results equal enabled count",
            vld_cnt - base_v, $countones(m));
      check(data_rdy, "R3 random pass data_rdy", data_rdy, 1);
    end

    // Full-scale extremes at depth 128
    chan_en = 4'b0100; avg_code = 3'd7; data_mode = 1;
    pulse_start(); wait_idle("R4 max run idle");
    check(res_of(2) == 32767, "R4 full-scale positive", res_of(2), 32767);
    data_mode = 2;
    pulse_start(); wait_idle("R4 min run idle");
    check(res_of(2) == -32768, "R4 full-scale negative", res_of(2), -32768);
    data_mode = 0;

    // Continuous then switch back: pass completes
    chan_en = 4'b1111; avg_code = 3'd1; mode_cont = 1'b1; base_v = vld_cnt;
    pulse_start();
    t = 0;
    while ((vld_cnt - base_v) < 13 && t < 20000) begin @(negedge clk); t++; end
    check(busy, "R3 continuous keeps running", busy, 1);
    mode_cont = 1'b0;
    wait_idle("R3 continuous stops at wrap");
    check((vld_cnt - base_v) % 4 == 0, "R3 last pass completes", (vld_cnt - base_v) % 4, 0);
    check(data_rdy, "R3 data_rdy after continuous", data_rdy, 1);

    // R8: depth change mid-slot
    chan_en = 4'b0001; avg_code = 3'd3; base_v = vld_cnt; base_s = rsp_cnt;
    pulse_start();
    t = 0;
    while ((rsp_cnt - base_s) < 2 && t < 2000) begin @(negedge clk); t++; end
    avg_code = 3'd0;
    wait_idle("R8 run idle");
    check(vld_cnt - base_v == 1, "R8 one result for slot", vld_cnt - base_v, 1);
    check(rsp_cnt - base_s == 8, "R8 old depth kept in slot", rsp_cnt - base_s, 8);
    base_s = rsp_cnt;
    pulse_start(); wait_idle("R8 next run idle");
    check(rsp_cnt - base_s == 1, "R8 new depth applies next slot", rsp_cnt - base_s, 1);

    // R6: power-down mid-average
    chan_en = 4'b0110; avg_code = 3'd4; mode_cont = 1'b1; base_s = rsp_cnt;
    pulse_start();
    t = 0;
    while ((rsp_cnt - base_s) < 3 && t < 2000) begin @(negedge clk); t++; end
    snap = res_flat; base_v = vld_cnt;
    pd_req = 1'b1;
    wait_idle("R6 power-down stops");
    repeat (3) @(negedge clk);
    check(res_flat == snap, "R6 results kept", res_flat, snap);
    check(vld_cnt == base_v, "R6 partial average dropped", vld_cnt - base_v, 0);
    for (int c = 0; c < NCH; c++) begin sum_c[c] = 0; cnt_c[c] = 0; end
    base_r = req_cnt;
    pulse_start();
    repeat (30) @(negedge clk);
    check(!busy, "R6 start ignored in power-down", busy, 0);
    check(req_cnt == base_r, "R6 no requests in power-down", req_cnt - base_r, 0);
    pd_req = 1'b0; mode_cont = 1'b0;
    chan_en = 4'b0110; avg_code = 3'd1;
    pulse_start(); wait_idle("R6 resume after power-down");
    check(data_rdy, "R6 resumes normally", data_rdy, 1);

    summary();
    $finish;
  end
endmodule